// File: doc/BRIEF.md
# Two-Street Signal Controller with Parade Hold

This block sequences the lamps at a crossing of two streets, called A and B. Each street has a vehicle sensor. Each street's lamp is driven by a 2-bit code. The controller gives right of way to one street at a time. It passes through a single-cycle yellow interval at every handover, so one clock tick is one yellow interval. Right of way moves away from a street only once its sensor reports no traffic.

The control is split into two cooperating machines. A parade machine holds a registered flag. The flag is set by a set strobe and dropped by a clear strobe; when both strobes arrive in the same cycle, the clear wins. A lights machine walks four phases. While the flag is up, the lights machine keeps street B green no matter what B's sensor reports. All pins are plain level controls; no data stream passes through the block, so there is no handshake. An active-high synchronous reset starts the block with A green and the flag down.

Top module: `parade_light_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `lamp_a` is 00 (green), `lamp_b` is 10 (red) and `parade_on` is 0.
- R2: In the A-green phase (`lamp_a`=00, `lamp_b`=10), the controller stays put while `sense_a` is 1 and moves to the A-yellow phase on an edge where `sense_a` is 0.
- R3: The A-yellow phase (`lamp_a`=01, `lamp_b`=10) lasts exactly one cycle, then the B-green phase follows.
- R4: In the B-green phase (`lamp_a`=10, `lamp_b`=00), with `parade_on` at 0, the controller stays while `sense_b` is 1 and moves to the B-yellow phase on an edge where `sense_b` is 0.
- R5: The B-yellow phase (`lamp_a`=10, `lamp_b`=01) lasts exactly one cycle, then the A-green phase follows.
- R6: While `parade_on` is 1 at a clock edge in the B-green phase, the controller remains in B-green whatever `sense_b` is.
- R7: `parade_on` becomes 1 after an edge with `parade_set`=1 and `parade_clr`=0. It becomes 0 after an edge with `parade_clr`=1, including when `parade_set` is also 1. Otherwise it holds.
- R8: Neither lamp output ever carries the code 11.
- R9: The lights machine reads the registered flag. A set strobe therefore reaches the phase logic one cycle later, and outside the B-green phase the flag has no effect on the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one yellow interval |
| rst | input | 1 | Active-high synchronous reset |
| sense_a | input | 1 | Traffic present on street A |
| sense_b | input | 1 | Traffic present on street B |
| parade_set | input | 1 | Strobe that raises the parade flag |
| parade_clr | input | 1 | Strobe that drops the parade flag (wins over set) |
| lamp_a | output | 2 | Street A lamp: 00 green, 01 yellow, 10 red |
| lamp_b | output | 2 | Street B lamp: 00 green, 01 yellow, 10 red |
| parade_on | output | 1 | Parade flag, registered |

## Verification
A sweep applies all sixteen combinations of the two sensors and two strobes, over and over, so that every combination lands in every phase with the flag both up and down. A reference model computed in the bench separates the phase hold cases (R2, R4, R6) from the forced advances (R3, R5). Directed sequences then tell apart a simultaneous set and clear, and a set that arrives in B-green with `sense_b` low, which must still leave B-green because the flag is registered. A reset asserted in the middle of a parade shows that the flag is cleared.

// File: rtl/parade_light_pkg.sv
package parade_light_pkg;
  localparam int LAMP_W  = 2;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phase_t;

  localparam logic [LAMP_W-1:0] LAMP_GO   = 2'b00;
  localparam logic [LAMP_W-1:0] LAMP_WARN = 2'b01;
  localparam logic [LAMP_W-1:0] LAMP_STOP = 2'b10;
  localparam logic [LAMP_W-1:0] LAMP_BAD  = 2'b11;
endpackage

// File: rtl/parade_mode_fsm.sv
module parade_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_clr_wins_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_o);
  assert_set_raises_R7: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> flag_o);
  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
  assert_reset_flag_R1: assert property (@(posedge clk)
    $past(rst) |-> !flag_o);
endmodule

// File: rtl/light_seq_fsm.sv
module light_seq_fsm
  import parade_light_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sense_a_i,
  input  logic   sense_b_i,
  input  logic   hold_b_i,
  output phase_t phase_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_A_GO:   phase_d = sense_a_i ? PH_A_GO : PH_A_WARN;
      PH_A_WARN: phase_d = PH_B_GO;
      PH_B_GO:   phase_d = (hold_b_i || sense_b_i) ? PH_B_GO : PH_B_WARN;
      PH_B_WARN: phase_d = PH_A_GO;
      default:   phase_d = PH_A_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_A_GO;
    else     phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_reset_phase_R1: assert property (@(posedge clk)
    $past(rst) |-> phase_q == PH_A_GO);
  assert_a_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_A_GO && sense_a_i) |=> phase_q == PH_A_GO);
  assert_a_warn_once_R3: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_A_WARN |=> phase_q == PH_B_GO);
  assert_b_release_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_B_GO && !hold_b_i && !sense_b_i) |=> phase_q == PH_B_WARN);
  assert_b_warn_once_R5: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_B_WARN |=> phase_q == PH_A_GO);
  assert_parade_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_B_GO && hold_b_i) |=> phase_q == PH_B_GO);
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import parade_light_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_i,
  output logic [LAMP_W-1:0] lamp_a_o,
  output logic [LAMP_W-1:0] lamp_b_o
);
  always_comb begin
    lamp_a_o = LAMP_STOP;
    lamp_b_o = LAMP_STOP;
    unique case (phase_i)
      PH_A_GO:   lamp_a_o = LAMP_GO;
      PH_A_WARN: lamp_a_o = LAMP_WARN;
      PH_B_GO:   lamp_b_o = LAMP_GO;
      PH_B_WARN: lamp_b_o = LAMP_WARN;
      default:   ;
    endcase
  end

  assert_no_code3_R8: assert property (@(posedge clk) disable iff (rst)
    lamp_a_o != LAMP_BAD && lamp_b_o != LAMP_BAD);
  assert_one_street_moves_R8: assert property (@(posedge clk) disable iff (rst)
    lamp_a_o == LAMP_STOP || lamp_b_o == LAMP_STOP);
endmodule

// File: rtl/parade_light_ctrl.sv
module parade_light_ctrl
  import parade_light_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_a,
  input  logic              sense_b,
  input  logic              parade_set,
  input  logic              parade_clr,
  output logic [LAMP_W-1:0] lamp_a,
  output logic [LAMP_W-1:0] lamp_b,
  output logic              parade_on
);
  logic   flag;
  phase_t phase;

  parade_mode_fsm u_mode (
    .clk   (clk),
    .rst   (rst),
    .set_i (parade_set),
    .clr_i (parade_clr),
    .flag_o(flag)
  );

  light_seq_fsm u_seq (
    .clk      (clk),
    .rst      (rst),
    .sense_a_i(sense_a),
    .sense_b_i(sense_b),
    .hold_b_i (flag),
    .phase_o  (phase)
  );

  lamp_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .phase_i (phase),
    .lamp_a_o(lamp_a),
    .lamp_b_o(lamp_b)
  );

  assign parade_on = flag;

  assert_flag_lag_R9: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == LAMP_GO && !parade_on && !sense_b) |=> lamp_b == LAMP_WARN);
endmodule

// File: tb/parade_light_ctrl_test.sv
module parade_light_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_a = 1'b0, sense_b = 1'b0, parade_set = 1'b0, parade_clr = 1'b0;
  logic [1:0] lamp_a, lamp_b;
  logic parade_on;

  int errors = 0;
  int checks = 0;
  int m_phase = 0;
  logic m_flag = 1'b0;

  always #10 clk = ~clk;

  parade_light_ctrl uut (
    .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
    .parade_set(parade_set), .parade_clr(parade_clr),
    .lamp_a(lamp_a), .lamp_b(lamp_b), .parade_on(parade_on)
  );

  function automatic logic [1:0] exp_a(int ph);
    return (ph == 0) ? 2'b00 : (ph == 1) ? 2'b01 : 2'b10;
  endfunction
  function automatic logic [1:0] exp_b(int ph);
    return (ph == 2) ? 2'b00 : (ph == 3) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got a/b/flag=%b expected %b", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, {lamp_a, lamp_b, parade_on}, {exp_a(m_phase), exp_b(m_phase), m_flag});
    checks++;
    if (lamp_a == 2'b11 || lamp_b == 2'b11) begin
      errors++;
      $display("FAIL R8: got lamps %b/%b expected no 11", lamp_a, lamp_b);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(logic ta, logic tb, logic ps, logic pc);
    string req;
    sense_a = ta; sense_b = tb; parade_set = ps; parade_clr = pc;
    @(posedge clk);
    case (m_phase)
      0: begin req = "R2"; m_phase = ta ? 0 : 1; end
      1: begin req = "R3"; m_phase = 2; end
      2: begin req = m_flag ? "R6" : "R4"; m_phase = (m_flag || tb) ? 2 : 3; end
      default: begin req = "R5"; m_phase = 0; end
    endcase
    if (pc) m_flag = 1'b0;
    else if (ps) m_flag = 1'b1;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    m_phase = 0; m_flag = 1'b0;
    @(negedge clk);
    check("R1", {lamp_a, lamp_b, parade_on}, 5'b00_10_0);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R2: A held while traffic; R3/R5 single-cycle yellows
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(0, 1, 0, 0);            // -> A yellow
    step(1, 1, 0, 0);            // -> B green (R3)
    step(0, 1, 0, 0);            // R4 hold
    step(0, 0, 0, 0);            // -> B yellow
    step(0, 1, 0, 0);            // -> A green (R5)

    // R7: set and clear together, clear wins
    step(1, 0, 1, 1);
    check("R7", {4'b0, parade_on}, 5'b0);
    step(1, 0, 1, 0);
    check("R7", {4'b0, parade_on}, 5'b1);
    // R9: flag up but in A phases sequence runs normally
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    check("R9", {lamp_a, lamp_b, 1'b0}, 5'b10_00_0);
    // R6: B held with no traffic on B
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0);
    check("R6", {lamp_a, lamp_b, 1'b0}, 5'b10_00_0);
    step(1, 0, 0, 1);            // clear; still B green this edge
    step(1, 0, 0, 0);            // now released
    check("R4", {lamp_a, lamp_b, 1'b0}, 5'b10_01_0);
    step(0, 0, 0, 0);

    // R9: set arriving in B green with sense_b low still leaves B green
    step(0, 0, 0, 0); step(0, 0, 0, 0);   // A yellow, B green
    step(0, 0, 1, 0);
    check("R9", {lamp_a, lamp_b, parade_on}, 5'b10_01_1);
    step(0, 0, 0, 1);

    // R1: reset in the middle of a parade clears the flag
    step(0, 1, 1, 0);
    do_reset();

    // near-exhaustive sweep of all input combinations in every phase
    for (int rep = 0; rep < 96; rep++) begin
      for (int c = 0; c < 16; c++) begin
        int v;
        v = (c + rep * 5) % 16;
        step(v[0] | (rep % 3 == 0), v[1] | (rep % 4 == 1), v[2] & (rep % 2 == 0), v[3] & (rep % 5 == 0));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule